// File: doc/BRIEF.md
# Dynamic Stream-Link Read Unit

This execution unit carries out a single instruction that fetches one word from one of up to sixteen incoming stream links, where the link number comes from a register value at run time. It decodes the instruction word itself and takes the index operand, the count of links actually present, and the data, valid and control lines of every link. It returns a write-back request for the destination register, a carry update, a sticky stream-error flag, a stall request toward the pipeline, an interrupt-inhibit level and an exception report. It pulses a read strobe toward the chosen link when the word is consumed.

Four instruction modifiers shape each access. A non-blocking read never stalls and reports through carry whether a word was there. A control read expects the link's control bit high, while a data read expects it low. A test-only read never strobes the link. The exception modifier turns a control-bit mismatch into an exception that keeps the destination unwritten. A further modifier holds off interrupts while the instruction is in flight. When protection is enabled, the override input is clear and the core runs in user mode, the instruction traps as privileged rather than reading.

The controller has four states. IDLE accepts a legal issue and goes to WAIT, or to TRAP when the privilege check fails. WAIT holds the stall until the selected link is valid, or finishes at once for a non-blocking read, and then moves to RESP. RESP and TRAP each last one cycle, raise `done`, and return to IDLE.

Top module: `strm_get_unit`

## Requirements
- R1: An issue is accepted only in IDLE and only when the instruction word, with bit 31 as the most significant bit, has opcode `[31:26]=6'b010011`, zero in `[20:16]`, zero in `[10]` and zero in `[4:0]`. Any other word is ignored: no stall, no strobe and no `done`.
- R2: The link index is `idx_val[3:0]`. When that value is greater than or equal to `num_links` (or to the built-in link count), link 0 is used instead. Higher bits of `idx_val` have no effect.
- R3: Blocking read (`[9]=0`): `stall` is high in every WAIT cycle in which the selected link is not valid, and it drops in the cycle the link becomes valid.
- R4: Non-blocking read (`[9]=1`): the unit never stalls. In RESP, `carry_wr` is 1 and `carry_out` is 0 if the link was valid and 1 if it was not. Blocking reads leave `carry_wr` at 0.
- R5: The expected control bit is `[8]` (0 for a data read, 1 for a control read). A valid word whose control bit differs sets `strm_err`, which stays set until reset. A matching read leaves it unchanged.
- R6: With the exception modifier `[5]=1`, a mismatch raises `exc_raise` in RESP with `exc_cause=5'h01`, `exc_link` equal to the selected index and `exc_data` equal to the word read, and `wb_en` stays 0. Without `[5]`, a mismatch still writes back.
- R7: Test-only reads (`[7]=1`) complete like normal reads but never assert any `link_rd` bit.
- R8: `link_rd` is one-hot or zero. It is asserted for exactly one cycle, on the selected link, in the WAIT cycle where that link is valid. It is never asserted on an invalid non-blocking access.
- R9: With the atomic modifier `[6]=1`, `int_inhibit` is high while the instruction is in flight. Otherwise it stays low.
- R10: When `prot_en=1`, `priv_ovr=0` and `user_mode=1` at issue, the unit goes to TRAP. It raises `exc_raise` with `exc_cause=5'h07` and `done`, with no strobe, no write-back and no stall. Setting `priv_ovr` restores a normal read.
- R11: After reset, `stall`, `done`, `wb_en`, `exc_raise`, `carry_wr`, `int_inhibit`, `strm_err` and all `link_rd` bits are 0.
- R12: `done` is a one-cycle pulse in the cycle after the read finishes. In that cycle `wb_en` is valid, `wb_data` holds the link word and `wb_dst` equals instruction bits `[25:21]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue | input | 1 | Instruction presented this cycle |
| instr | input | 32 | Instruction word |
| idx_val | input | 32 | Index operand value |
| num_links | input | 5 | Number of configured links (0 to 16) |
| link_data | input | NL*W | Packed link words, link i at bits i*W |
| link_valid | input | NL | Per-link data valid |
| link_ctrl | input | NL | Per-link control bit |
| prot_en | input | 1 | Protection enabled |
| priv_ovr | input | 1 | Allow the instruction in user mode |
| user_mode | input | 1 | Core runs in user mode |
| link_rd | output | NL | One-hot read strobe to the links |
| stall | output | 1 | Pipeline stall request |
| int_inhibit | output | 1 | Interrupts held off |
| done | output | 1 | Instruction completes |
| wb_en | output | 1 | Destination register write enable |
| wb_dst | output | 5 | Destination register number |
| wb_data | output | W | Destination write data |
| carry_wr | output | 1 | Carry update enable |
| carry_out | output | 1 | Carry value |
| strm_err | output | 1 | Sticky control-mismatch flag |
| exc_raise | output | 1 | Exception raised |
| exc_cause | output | 5 | Exception cause code |
| exc_link | output | 4 | Link index of a stream exception |
| exc_data | output | W | Word captured on a stream exception |

## Verification
A controller stuck in WAIT appears at once as `stall` held with no strobe and no `done`. A slip through RESP shows up one cycle later as a missing or doubled `done`. A wrongly latched index is seen in the same cycle as a strobe on the wrong `link_rd` bit, and in RESP as the wrong word in `wb_data` or `exc_data`. Corrupted modifier state shows up at the end of a single instruction as a carry, write-enable or exception pulse that disagrees with the instruction word. A lost sticky bit is seen on the next read that matches its control bit.

// File: rtl/strm_get_pkg.sv
package strm_get_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_RESP,
        ST_TRAP
    } get_state_t;

    // decoded modifiers and destination of one instruction
    typedef struct packed {
        logic       nb;   // non-blocking
        logic       ctl;  // expected control bit
        logic       tst;  // test-only, no strobe
        logic       atm;  // interrupts held off
        logic       exc;  // trap on control mismatch
        logic [4:0] dst;
    } get_op_t;

    localparam logic [5:0] OPC_GET      = 6'b010011;
    localparam logic [4:0] CAUSE_STREAM = 5'h01;
    localparam logic [4:0] CAUSE_PRIV   = 5'h07;
    localparam int         IDXW         = 4;

endpackage

// File: rtl/strm_get_decode.sv
module strm_get_decode
    import strm_get_pkg::*;
(
    input  logic [31:0] instr,
    output logic        legal,
    output get_op_t     op
);
    // word numbered with bit 31 as the first (most significant) bit
    assign legal = (instr[31:26] == OPC_GET) &&
                   (instr[20:16] == 5'd0)    &&
                   (instr[10]    == 1'b0)    &&
                   (instr[4:0]   == 5'd0);

    always_comb begin
        op.dst = instr[25:21];
        op.nb  = instr[9];
        op.ctl = instr[8];
        op.tst = instr[7];
        op.atm = instr[6];
        op.exc = instr[5];
    end
endmodule

// File: rtl/strm_link_sel.sv
module strm_link_sel #(
    parameter int NL = 16,
    parameter int W  = 32
) (
    input  logic [3:0]      idx_req,
    input  logic [4:0]      num_links,
    output logic [3:0]      idx_res,
    input  logic [3:0]      idx_cur,
    input  logic [NL*W-1:0] link_data,
    input  logic [NL-1:0]   link_valid,
    input  logic [NL-1:0]   link_ctrl,
    output logic [W-1:0]    sel_data,
    output logic            sel_valid,
    output logic            sel_ctrl
);
    localparam int         SW     = (NL > 1) ? $clog2(NL) : 1;
    localparam logic [4:0] NL_LIM = 5'(NL);

    logic [W-1:0] lane [NL];

    generate
        for (genvar g = 0; g < NL; g++) begin : g_lane
            assign lane[g] = link_data[g*W +: W];
        end
    endgenerate

    logic in_range;
    assign in_range = ({1'b0, idx_req} < num_links) && ({1'b0, idx_req} < NL_LIM);
    assign idx_res  = in_range ? idx_req : '0;

    assign sel_data  = lane[idx_cur[SW-1:0]];
    assign sel_valid = link_valid[idx_cur[SW-1:0]];
    assign sel_ctrl  = link_ctrl[idx_cur[SW-1:0]];
endmodule

// File: rtl/strm_get_fsm.sv
module strm_get_fsm
    import strm_get_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    start,
    input  logic    priv_fault,
    input  get_op_t op_q,
    input  logic    sel_valid,
    input  logic    exc_take_q,
    output logic    idle,
    output logic    finish,
    output logic    rd_fire,
    output logic    stall,
    output logic    done,
    output logic    wb_en,
    output logic    exc_raise,
    output logic    carry_wr,
    output logic    int_inhibit
);
    get_state_t state, nxt;

    assign idle   = (state == ST_IDLE);
    assign finish = (state == ST_WAIT) && (sel_valid || op_q.nb);

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (start)  nxt = priv_fault ? ST_TRAP : ST_WAIT;
            ST_WAIT: if (finish) nxt = ST_RESP;
            ST_RESP: nxt = ST_IDLE;
            ST_TRAP: nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        rd_fire     = 1'b0;
        stall       = 1'b0;
        done        = 1'b0;
        wb_en       = 1'b0;
        exc_raise   = 1'b0;
        carry_wr    = 1'b0;
        int_inhibit = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_WAIT: begin
                stall       = !finish;
                rd_fire     = sel_valid && !op_q.tst;
                int_inhibit = op_q.atm;
            end
            ST_RESP: begin
                done        = 1'b1;
                wb_en       = !exc_take_q;
                exc_raise   = exc_take_q;
                carry_wr    = op_q.nb;
                int_inhibit = op_q.atm;
            end
            ST_TRAP: begin
                done        = 1'b1;
                exc_raise   = 1'b1;
                int_inhibit = op_q.atm;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/strm_get_result.sv
module strm_get_result
    import strm_get_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  get_op_t      op_in,
    input  logic [3:0]   sel_in,
    input  logic         priv_in,
    input  logic         finish,
    input  logic [W-1:0] sel_data,
    input  logic         sel_valid,
    input  logic         sel_ctrl,
    output get_op_t      op_q,
    output logic [3:0]   sel_q,
    output logic [W-1:0] data_q,
    output logic         exc_take_q,
    output logic         carry_q,
    output logic         err_q,
    output logic [4:0]   cause_q,
    output logic [3:0]   link_q,
    output logic [W-1:0] edata_q
);
    logic mism;
    assign mism = sel_valid && (sel_ctrl != op_q.ctl);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q       <= '0;
            sel_q      <= '0;
            data_q     <= '0;
            exc_take_q <= 1'b0;
            carry_q    <= 1'b0;
            err_q      <= 1'b0;
            cause_q    <= '0;
            link_q     <= '0;
            edata_q    <= '0;
        end else if (start) begin
            op_q  <= op_in;
            sel_q <= sel_in;
            if (priv_in) begin
                cause_q <= CAUSE_PRIV;
                link_q  <= '0;
            end
        end else if (finish) begin
            data_q     <= sel_data;
            exc_take_q <= mism && op_q.exc;
            if (mism)
                err_q <= 1'b1;
            if (op_q.nb)
                carry_q <= !sel_valid;
            if (mism && op_q.exc) begin
                cause_q <= CAUSE_STREAM;
                link_q  <= sel_q;
                edata_q <= sel_data;
            end
        end
    end
endmodule

// File: rtl/strm_get_unit.sv
module strm_get_unit
    import strm_get_pkg::*;
#(
    parameter int NL = 16,
    parameter int W  = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            issue,
    input  logic [31:0]     instr,
    input  logic [31:0]     idx_val,
    input  logic [4:0]      num_links,
    input  logic [NL*W-1:0] link_data,
    input  logic [NL-1:0]   link_valid,
    input  logic [NL-1:0]   link_ctrl,
    input  logic            prot_en,
    input  logic            priv_ovr,
    input  logic            user_mode,
    output logic [NL-1:0]   link_rd,
    output logic            stall,
    output logic            int_inhibit,
    output logic            done,
    output logic            wb_en,
    output logic [4:0]      wb_dst,
    output logic [W-1:0]    wb_data,
    output logic            carry_wr,
    output logic            carry_out,
    output logic            strm_err,
    output logic            exc_raise,
    output logic [4:0]      exc_cause,
    output logic [3:0]      exc_link,
    output logic [W-1:0]    exc_data
);
    logic        legal, idle, start, priv_fault, finish, rd_fire;
    logic        sel_valid, sel_ctrl, exc_take_q;
    logic [3:0]  idx_res, sel_q;
    logic [W-1:0] sel_data;
    get_op_t     op_dec, op_q;

    assign start      = issue && legal && idle;
    assign priv_fault = prot_en && !priv_ovr && user_mode;

    strm_get_decode i_dec (
        .instr (instr),
        .legal (legal),
        .op    (op_dec)
    );

    strm_link_sel #(.NL(NL), .W(W)) i_sel (
        .idx_req    (idx_val[IDXW-1:0]),
        .num_links  (num_links),
        .idx_res    (idx_res),
        .idx_cur    (sel_q),
        .link_data  (link_data),
        .link_valid (link_valid),
        .link_ctrl  (link_ctrl),
        .sel_data   (sel_data),
        .sel_valid  (sel_valid),
        .sel_ctrl   (sel_ctrl)
    );

    strm_get_fsm i_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .priv_fault  (priv_fault),
        .op_q        (op_q),
        .sel_valid   (sel_valid),
        .exc_take_q  (exc_take_q),
        .idle        (idle),
        .finish      (finish),
        .rd_fire     (rd_fire),
        .stall       (stall),
        .done        (done),
        .wb_en       (wb_en),
        .exc_raise   (exc_raise),
        .carry_wr    (carry_wr),
        .int_inhibit (int_inhibit)
    );

    strm_get_result #(.W(W)) i_res (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .op_in      (op_dec),
        .sel_in     (idx_res),
        .priv_in    (priv_fault),
        .finish     (finish),
        .sel_data   (sel_data),
        .sel_valid  (sel_valid),
        .sel_ctrl   (sel_ctrl),
        .op_q       (op_q),
        .sel_q      (sel_q),
        .data_q     (wb_data),
        .exc_take_q (exc_take_q),
        .carry_q    (carry_out),
        .err_q      (strm_err),
        .cause_q    (exc_cause),
        .link_q     (exc_link),
        .edata_q    (exc_data)
    );

    assign wb_dst = op_q.dst;

    generate
        for (genvar g = 0; g < NL; g++) begin : g_strobe
            assign link_rd[g] = rd_fire && (sel_q == 4'(g));
        end
    endgenerate
endmodule

// File: rtl/strm_get_chk.sv
module strm_get_chk #(
    parameter int NL = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic [NL-1:0] link_rd,
    input logic [NL-1:0] link_valid,
    input logic          stall,
    input logic          done,
    input logic          wb_en,
    input logic          exc_raise,
    input logic          carry_wr,
    input logic          strm_err
);
    // R8
    rd_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(link_rd));

    // R8
    rd_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (link_rd & ~link_valid) == '0);

    // R12
    rd_then_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|link_rd) |=> done);

    // R3
    stall_not_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> !done && (link_rd == '0));

    // R5
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strm_err |=> strm_err);

    // R6
    exc_blocks_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_raise |-> done && !wb_en);

    // R4
    carry_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        carry_wr |-> done);
endmodule

bind strm_get_unit strm_get_chk #(.NL(NL)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .link_rd    (link_rd),
    .link_valid (link_valid),
    .stall      (stall),
    .done       (done),
    .wb_en      (wb_en),
    .exc_raise  (exc_raise),
    .carry_wr   (carry_wr),
    .strm_err   (strm_err)
);

// File: tb/test_strm_get_unit.sv
module test_strm_get_unit;
    localparam int CLK_PER = 10;
    localparam int NL = 16;
    localparam int W  = 32;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            issue;
    logic [31:0]     instr_i, idx_val;
    logic [4:0]      num_links;
    logic [NL*W-1:0] link_data;
    logic [NL-1:0]   link_valid, link_ctrl, link_rd;
    logic            prot_en, priv_ovr, user_mode;
    logic            stall, int_inhibit, done, wb_en, carry_wr, carry_out, strm_err, exc_raise;
    logic [4:0]      wb_dst, exc_cause;
    logic [3:0]      exc_link;
    logic [W-1:0]    wb_data, exc_data;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PER/2) clk = ~clk;

    strm_get_unit #(.NL(NL), .W(W)) i_strm_get_unit (
        .clk(clk), .rst_n(rst_n), .issue(issue), .instr(instr_i), .idx_val(idx_val),
        .num_links(num_links), .link_data(link_data), .link_valid(link_valid),
        .link_ctrl(link_ctrl), .prot_en(prot_en), .priv_ovr(priv_ovr),
        .user_mode(user_mode), .link_rd(link_rd), .stall(stall),
        .int_inhibit(int_inhibit), .done(done), .wb_en(wb_en), .wb_dst(wb_dst),
        .wb_data(wb_data), .carry_wr(carry_wr), .carry_out(carry_out),
        .strm_err(strm_err), .exc_raise(exc_raise), .exc_cause(exc_cause),
        .exc_link(exc_link), .exc_data(exc_data)
    );

    // observations of one instruction
    int          stalls, rd_cnt;
    logic [NL-1:0] rd_obs;
    logic        inh_seen, done_seen, after_done;
    logic        g_wb_en, g_carry_wr, g_carry, g_err, g_exc;
    logic [4:0]  g_dst, g_cause;
    logic [3:0]  g_link;
    logic [W-1:0] g_data, g_edata;

    function automatic logic [31:0] mk(input logic [4:0] dst, input logic n, c, t, a, e);
        return {6'b010011, dst, 5'd0, 5'd7, 1'b0, n, c, t, a, e, 5'd0};
    endfunction

    function automatic logic [W-1:0] lane_val(input int i);
        return 32'hC0DE_0000 + 32'(i);
    endfunction

    task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", rq, act, exp);
        end
    endtask

    task automatic run_op(input logic [31:0] ins, input logic [31:0] idx,
                          input logic [NL-1:0] vmask, input logic [NL-1:0] cmask,
                          input int dly);
        @(negedge clk);
        instr_i    = ins;
        idx_val    = idx;
        link_ctrl  = cmask;
        link_valid = (dly == 0) ? vmask : '0;
        issue      = 1'b1;
        @(negedge clk);
        issue   = 1'b0;
        instr_i = '0;
        stalls = 0; rd_cnt = 0; rd_obs = '0; inh_seen = 1'b0; done_seen = 1'b0;
        for (int cyc = 0; cyc < 20; cyc++) begin
            if (cyc == dly) link_valid = vmask;
            #1;
            inh_seen = inh_seen | int_inhibit;
            if (done) begin
                done_seen  = 1'b1;
                g_wb_en    = wb_en;   g_carry_wr = carry_wr; g_carry = carry_out;
                g_err      = strm_err; g_exc     = exc_raise; g_dst   = wb_dst;
                g_cause    = exc_cause; g_link   = exc_link;  g_data  = wb_data;
                g_edata    = exc_data;
                break;
            end
            if (stall) stalls++;
            if (link_rd != '0) begin
                rd_obs = rd_obs | link_rd;
                rd_cnt = rd_cnt + $countones(link_rd);
            end
            @(negedge clk);
        end
        @(negedge clk);
        #1;
        after_done = done;
        link_valid = '0;
    endtask

    task automatic t_reset;
        chk("R11 stall", 64'(stall), 64'(0));
        chk("R11 done", 64'(done), 64'(0));
        chk("R11 link_rd", 64'(link_rd), 64'(0));
        chk("R11 strm_err", 64'(strm_err), 64'(0));
        chk("R11 exc_raise", 64'(exc_raise), 64'(0));
        chk("R11 int_inhibit", 64'(int_inhibit), 64'(0));
        chk("R11 wb_en", 64'(wb_en), 64'(0));
        chk("R11 carry_wr", 64'(carry_wr), 64'(0));
    endtask

    task automatic t_blocking;
        run_op(mk(5'd11, 0, 0, 0, 0, 0), 32'd5, 16'h0020, 16'h0000, 3);
        chk("R3 stall cycles", 64'(stalls), 64'(3));
        chk("R8 strobe link", 64'(rd_obs), 64'(16'h0020));
        chk("R8 strobe count", 64'(rd_cnt), 64'(1));
        chk("R12 done seen", 64'(done_seen), 64'(1));
        chk("R12 done one cycle", 64'(after_done), 64'(0));
        chk("R12 wb_en", 64'(g_wb_en), 64'(1));
        chk("R12 wb_data", 64'(g_data), 64'(lane_val(5)));
        chk("R12 wb_dst", 64'(g_dst), 64'(11));
        chk("R4 blocking no carry_wr", 64'(g_carry_wr), 64'(0));
        chk("R9 no inhibit", 64'(inh_seen), 64'(0));
        chk("R6 no exception", 64'(g_exc), 64'(0));
    endtask

    task automatic t_index;
        num_links = 5'd4;
        run_op(mk(5'd2, 0, 0, 0, 0, 0), 32'h0000_1239, 16'hFFFF, 16'h0000, 0);
        chk("R2 fallback strobe", 64'(rd_obs), 64'(16'h0001));
        chk("R2 fallback data", 64'(g_data), 64'(lane_val(0)));
        run_op(mk(5'd2, 0, 0, 0, 0, 0), 32'h0000_0004, 16'hFFFF, 16'h0000, 0);
        chk("R2 equal count falls back", 64'(rd_obs), 64'(16'h0001));
        run_op(mk(5'd2, 0, 0, 0, 0, 0), 32'h0000_0003, 16'hFFFF, 16'h0000, 0);
        chk("R2 last in range", 64'(rd_obs), 64'(16'h0008));
        num_links = 5'd16;
        run_op(mk(5'd2, 0, 0, 0, 0, 0), 32'hABCD_00F3, 16'hFFFF, 16'h0000, 0);
        chk("R2 high bits ignored", 64'(rd_obs), 64'(16'h0008));
        chk("R2 high bits data", 64'(g_data), 64'(lane_val(3)));
        run_op(mk(5'd2, 0, 0, 0, 0, 0), 32'h0000_000F, 16'hFFFF, 16'h0000, 0);
        chk("R2 link 15", 64'(g_data), 64'(lane_val(15)));
    endtask

    task automatic t_nonblock;
        run_op(mk(5'd4, 1, 0, 0, 0, 0), 32'd6, 16'h0000, 16'h0000, 0);
        chk("R4 invalid no stall", 64'(stalls), 64'(0));
        chk("R8 invalid no strobe", 64'(rd_cnt), 64'(0));
        chk("R4 carry_wr", 64'(g_carry_wr), 64'(1));
        chk("R4 carry set", 64'(g_carry), 64'(1));
        run_op(mk(5'd4, 1, 0, 0, 0, 0), 32'd6, 16'h0040, 16'h0000, 0);
        chk("R4 valid carry clear", 64'(g_carry), 64'(0));
        chk("R8 valid strobe", 64'(rd_obs), 64'(16'h0040));
        chk("R4 valid data", 64'(g_data), 64'(lane_val(6)));
    endtask

    task automatic t_test_only;
        run_op(mk(5'd9, 0, 0, 1, 0, 0), 32'd8, 16'h0100, 16'h0000, 2);
        chk("R7 no strobe", 64'(rd_cnt), 64'(0));
        chk("R7 waits like normal", 64'(stalls), 64'(2));
        chk("R7 wb data", 64'(g_data), 64'(lane_val(8)));
        chk("R7 wb_en", 64'(g_wb_en), 64'(1));
    endtask

    task automatic t_control;
        run_op(mk(5'd1, 0, 1, 0, 0, 0), 32'd2, 16'h0004, 16'h0004, 0);
        chk("R5 control match no error", 64'(g_err), 64'(0));
        run_op(mk(5'd1, 0, 0, 0, 0, 0), 32'd2, 16'h0004, 16'h0004, 0);
        chk("R5 data read mismatch sets error", 64'(g_err), 64'(1));
        chk("R6 no trap without modifier", 64'(g_exc), 64'(0));
        chk("R6 write-back kept without modifier", 64'(g_wb_en), 64'(1));
        run_op(mk(5'd1, 0, 0, 0, 0, 0), 32'd2, 16'h0004, 16'h0000, 0);
        chk("R5 error sticky", 64'(g_err), 64'(1));
    endtask

    task automatic t_exception;
        run_op(mk(5'd3, 0, 1, 0, 0, 1), 32'd7, 16'h0080, 16'h0000, 0);
        chk("R6 exc_raise", 64'(g_exc), 64'(1));
        chk("R6 wb suppressed", 64'(g_wb_en), 64'(0));
        chk("R6 cause", 64'(g_cause), 64'(5'h01));
        chk("R6 link index", 64'(g_link), 64'(7));
        chk("R6 captured word", 64'(g_edata), 64'(lane_val(7)));
        run_op(mk(5'd3, 0, 1, 0, 0, 1), 32'd9, 16'h0200, 16'h0200, 0);
        chk("R6 match with modifier no trap", 64'(g_exc), 64'(0));
        chk("R6 match writes back", 64'(g_wb_en), 64'(1));
    endtask

    task automatic t_atomic;
        run_op(mk(5'd5, 0, 0, 0, 1, 0), 32'd1, 16'h0002, 16'h0000, 2);
        chk("R9 inhibit while in flight", 64'(inh_seen), 64'(1));
        chk("R9 inhibit released", 64'(int_inhibit), 64'(0));
    endtask

    task automatic t_priv;
        prot_en = 1'b1; priv_ovr = 1'b0; user_mode = 1'b1;
        run_op(mk(5'd6, 0, 0, 0, 0, 0), 32'd2, 16'h0004, 16'h0000, 0);
        chk("R10 trap raised", 64'(g_exc), 64'(1));
        chk("R10 trap cause", 64'(g_cause), 64'(5'h07));
        chk("R10 no strobe", 64'(rd_cnt), 64'(0));
        chk("R10 no wb", 64'(g_wb_en), 64'(0));
        chk("R10 no stall", 64'(stalls), 64'(0));
        priv_ovr = 1'b1;
        run_op(mk(5'd6, 0, 0, 0, 0, 0), 32'd2, 16'h0004, 16'h0000, 0);
        chk("R10 override reads", 64'(rd_obs), 64'(16'h0004));
        chk("R10 override no trap", 64'(g_exc), 64'(0));
        prot_en = 1'b0; priv_ovr = 1'b0; user_mode = 1'b0;
    endtask

    task automatic t_illegal;
        logic [31:0] bad;
        bad = mk(5'd1, 0, 0, 0, 0, 0);
        bad[31:26] = 6'b010010;
        run_op(bad, 32'd1, 16'hFFFF, 16'h0000, 0);
        chk("R1 wrong opcode no done", 64'(done_seen), 64'(0));
        chk("R1 wrong opcode no strobe", 64'(rd_cnt), 64'(0));
        chk("R1 wrong opcode no stall", 64'(stalls), 64'(0));
        bad = mk(5'd1, 0, 0, 0, 0, 0);
        bad[10] = 1'b1;
        run_op(bad, 32'd1, 16'hFFFF, 16'h0000, 0);
        chk("R1 reserved bit no done", 64'(done_seen), 64'(0));
        bad = mk(5'd1, 0, 0, 0, 0, 0);
        bad[0] = 1'b1;
        run_op(bad, 32'd1, 16'hFFFF, 16'h0000, 0);
        chk("R1 low field no done", 64'(done_seen), 64'(0));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got hung expected finished");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; issue = 1'b0; instr_i = '0; idx_val = '0; num_links = 5'd16;
        link_valid = '0; link_ctrl = '0;
        prot_en = 1'b0; priv_ovr = 1'b0; user_mode = 1'b0;
        for (int i = 0; i < NL; i++) link_data[i*W +: W] = lane_val(i);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_blocking();
        t_index();
        t_nonblock();
        t_test_only();
        t_control();
        t_exception();
        t_atomic();
        t_priv();
        t_illegal();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule